// File: doc/BRIEF.md
# Digit-Serial Redundant-Basis Field Multiplier

This block multiplies two binary field elements that are held in redundant-basis form. Each operand is an N-bit vector, and bit i is the coefficient of x^i. The element x is a primitive N-th root of unity, so x^N = 1. Multiplying by x is therefore a cyclic rotation of the vector, and no reduction network is needed. Each cycle, the block takes W coefficients of the first operand. It gates a matching rotated copy of the second operand with each of those coefficients and folds the results into an N-bit accumulator with XOR. The product is ready after ceil(N/W) cycles.

The caller presents both operands in parallel and pulses `start` while the block is idle. The block drives `busy` for the duration of the multiplication, then pulses `done` for one cycle as the product register loads. The square of the registered product is also offered. It is a pure reordering of the product's coefficients and costs no arithmetic. Changing basis and reducing the redundant result to the field degree are left to the surrounding logic.

Top module: `rb_gf2m_mul`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is low latches both operands. From the next cycle, `busy` is high for exactly T = ceil(N/W) consecutive cycles.
- R3: `done` is high for exactly one cycle, which is the cycle right after `busy` falls. `busy` and `done` are never high together.
- R4: The loaded `product` equals the XOR, over every i with bit i of `op_l` set, of `op_m` rotated up by i places. Rotating up by i places means that bit (j+i) mod N of the copy equals bit j of `op_m`.
- R5: When N is not a multiple of W, the unused lanes of the last digit contribute nothing. A first operand with only bit N-1 set returns `op_m` rotated up by N-1.
- R6: `product` changes only at the clock edge that raises `done`. It holds its value while idle and during the next multiplication.
- R7: A `start` sampled while `busy` is high is ignored. The running multiplication keeps its timing and returns the product of the operands latched at acceptance.
- R8: `product_sq` is the field square of `product`. Bit (2i) mod N of `product_sq` is the XOR of the bits i of `product` that map to it. For odd N this is a permutation and equals `product` times `product` under R4.
- R9: A `start` applied in the same cycle as `done` is accepted, so back-to-back operations leave no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiplication; honoured only when not busy |
| op_l | input | N | First operand, bit i is the coefficient of x^i |
| op_m | input | N | Second operand, same layout |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse when `product` loads |
| product | output | N | Registered redundant-basis product |
| product_sq | output | N | Square of `product`, a fixed bit reordering |

## Verification
The bench builds the block with N = 7 and W = 3. This gives T = 3 digits, and the last digit carries only one live coefficient. With only 14 operand bits, every one of the 16,384 operand pairs can be multiplied and compared against a rotate-and-sum reference. That sweep covers the all-zero, all-one and single-bit operands, as well as the padded digit. Because 7 is odd, the square output can be checked as a second multiplication of the product by itself. Every run starts in the `done` cycle of the one before, so back-to-back acceptance is exercised throughout. Starts injected mid-run show that they are ignored.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

  typedef enum logic {
    RBM_IDLE = 1'b0,
    RBM_RUN  = 1'b1
  } rbm_state_e;

  function automatic int rbm_ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int rbm_cnt_width(input int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/rbm_rotate.sv
// Fixed cyclic rotation: multiplication by x^SHIFT in redundant basis.
module rbm_rotate #(
  parameter int N     = 7,
  parameter int SHIFT = 1
) (
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  localparam int SH = SHIFT % N;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign dout[(i + SH) % N] = din[i];
  end

endmodule

// File: rtl/rbm_digit_pp.sv
// Partial product of one W-coefficient digit against the current rotated M.
module rbm_digit_pp #(
  parameter int N = 7,
  parameter int W = 3
) (
  input  logic [N-1:0] m_cur,
  input  logic [W-1:0] digit,
  output logic [N-1:0] pp
);

  logic [N-1:0] rot  [W];
  logic [N-1:0] lane [W];

  for (genvar j = 0; j < W; j++) begin : g_lane
    rbm_rotate #(.N(N), .SHIFT(j)) u_rot (
      .din  (m_cur),
      .dout (rot[j])
    );
    assign lane[j] = digit[j] ? rot[j] : '0;
  end

  always_comb begin
    pp = '0;
    for (int j = 0; j < W; j++) begin
      pp = pp ^ lane[j];
    end
  end

endmodule

// File: rtl/rbm_square.sv
// Squaring in redundant basis: coefficient i moves to position 2i mod N.
module rbm_square #(
  parameter int N = 7
) (
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      dout[(2 * i) % N] = dout[(2 * i) % N] ^ din[i];
    end
  end

endmodule

// File: rtl/rbm_ctrl.sv
// Sequencer: accepts start when idle, counts T digit cycles, pulses done.
module rbm_ctrl
  import rbm_pkg::*;
#(
  parameter int T  = 3,
  parameter int CW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);

  rbm_state_e    state;
  logic [CW-1:0] cnt;

  assign load = (state == RBM_IDLE) && start;
  assign step = (state == RBM_RUN);
  assign last = step && (cnt == CW'(T - 1));
  assign busy = (state == RBM_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RBM_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        RBM_IDLE: begin
          if (start) begin
            state <= RBM_RUN;
            cnt   <= '0;
          end
        end
        RBM_RUN: begin
          if (last) begin
            state <= RBM_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RBM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rb_gf2m_mul.sv
// Digit-serial redundant-basis multiplier, top level.
module rb_gf2m_mul
  import rbm_pkg::*;
#(
  parameter int N = 7,
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] op_l,
  input  logic [N-1:0] op_m,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] product,
  output logic [N-1:0] product_sq
);

  localparam int T  = rbm_ceil_div(N, W);
  localparam int LW = T * W;
  localparam int CW = rbm_cnt_width(T);

  logic          load, step, last;
  logic [LW-1:0] l_reg;
  logic [N-1:0]  m_reg;
  logic [N-1:0]  m_next;
  logic [N-1:0]  acc;
  logic [N-1:0]  pp;
  logic [N-1:0]  acc_next;

  rbm_ctrl #(.T(T), .CW(CW)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .busy  (busy),
    .done  (done)
  );

  rbm_digit_pp #(.N(N), .W(W)) u_pp (
    .m_cur (m_reg),
    .digit (l_reg[W-1:0]),
    .pp    (pp)
  );

  rbm_rotate #(.N(N), .SHIFT(W)) u_adv (
    .din  (m_reg),
    .dout (m_next)
  );

  assign acc_next = acc ^ pp;

  always_ff @(posedge clk) begin
    if (rst) begin
      l_reg   <= '0;
      m_reg   <= '0;
      acc     <= '0;
      product <= '0;
    end else if (load) begin
      l_reg <= LW'(op_l);
      m_reg <= op_m;
      acc   <= '0;
    end else if (step) begin
      l_reg <= l_reg >> W;
      m_reg <= m_next;
      acc   <= acc_next;
      if (last) begin
        product <= acc_next;
      end
    end
  end

  rbm_square #(.N(N)) u_sq (
    .din  (product),
    .dout (product_sq)
  );

endmodule

// File: rtl/rbm_checker.sv
module rbm_checker
  import rbm_pkg::*;
#(
  parameter int N = 7,
  parameter int W = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] product
);

  localparam int T = rbm_ceil_div(N, W);

  int run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  a_r2_start_to_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r2_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == T));

  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r6_product_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(product) |-> done);

  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && run_len < T - 1) |=> busy);

endmodule

bind rb_gf2m_mul rbm_checker #(.N(N), .W(W)) u_rbm_checker (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/rb_gf2m_mul_tb.sv
module rb_gf2m_mul_tb;

  localparam int N = 7;
  localparam int W = 3;
  localparam int T = (N + W - 1) / W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] op_l = '0;
  logic [N-1:0] op_m = '0;
  logic         busy, done;
  logic [N-1:0] product, product_sq;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] prev_prod = '0;

  always #2.5 clk = ~clk;

  rb_gf2m_mul #(.N(N), .W(W)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op_l       (op_l),
    .op_m       (op_m),
    .busy       (busy),
    .done       (done),
    .product    (product),
    .product_sq (product_sq)
  );

  function automatic logic [N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (a[i] && b[j]) r[(i + j) % N] = r[(i + j) % N] ^ 1'b1;
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; leaves at the negedge where done should be high.
  task automatic run(input logic [N-1:0] l, input logic [N-1:0] m,
                     input logic inject, input string tag);
    int cycles;
    op_l  = l;
    op_m  = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2/R9 busy after start", longint'(busy), 1);
    chk(product === prev_prod, "R6 product held during run", longint'(product), longint'(prev_prod));
    cycles = 0;
    while (busy === 1'b1 && cycles <= T + 2) begin
      start = inject && (cycles == 0);
      if (start) begin
        op_l = ~l;
        op_m = ~m;
      end
      cycles++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cycles == T, "R2 busy length", longint'(cycles), longint'(T));
    chk(done === 1'b1, "R3 done after busy", longint'(done), 1);
    chk(product === ref_mul(l, m), tag, longint'(product), longint'(ref_mul(l, m)));
    chk(product_sq === ref_mul(product, product), "R8 square output",
        longint'(product_sq), longint'(ref_mul(product, product)));
    prev_prod = product;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 control idle in reset", longint'({busy, done}), 0);
    chk(product === '0, "R1 product zero in reset", longint'(product), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 control idle after reset", longint'({busy, done}), 0);
    chk(product === '0, "R1 product zero after reset", longint'(product), 0);

    // R5: only the coefficient in the padded last digit is set
    run(N'(1) << (N - 1), N'(1), 1'b0, "R5 padded digit x^(N-1)");
    run(N'(1) << (N - 1), N'(7'h55), 1'b0, "R5 padded digit rotation");
    chk(done === 1'b1, "R9 start in done cycle", longint'(done), 1);
    // R7: start injected mid-run with different operands
    run(N'(7'h2b), N'(7'h71), 1'b1, "R7 ignored start keeps operands");
    run('1, '1, 1'b1, "R7 all-ones with injected start");

    // R6: product held while idle
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(done === 1'b0, "R3 done single pulse", longint'(done), 0);
      chk(product === prev_prod, "R6 product held while idle", longint'(product), longint'(prev_prod));
    end

    // R4: exhaustive sweep, back-to-back runs (R9)
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        run(N'(a), N'(b), 1'b0, "R4 product");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule